// File: doc/BRIEF.md
# Stream-to-Lane Frame Encapsulator

This block sits on the transmit side of a framed serial link. It takes packets from an AXI4-Stream slave and turns them into a stream of lane bytes, each with a control flag, ready for an 8B/10B encoder. Every frame is wrapped in in-band delimiters. A start word goes ahead of the first data bytes, and an end word follows the last valid byte. Bytes left unused in a frame's final word are filled with pad symbols. Idle symbols fill any slot that carries no user data.

A frame opens with the first beat that presents `s_tvalid_i` after the previous frame closed. It closes on the beat that carries `s_tlast_i`. For that last beat, `s_tkeep_i` says how many leading bytes are valid. Dropping `s_tvalid_i` in the middle of a frame is legal and sends one idle slot per cycle. While a delimiter word is on the line, `s_tready_o` stays low. The logical output word is spread across `LANES` lanes of two bytes each. Logical byte k goes to lane k mod LANES. With the default setting there is a single two-byte lane.

Top module: `tx_frame_encap`

## Requirements
- R1: `s_tready_o` is high only in the data phase of a frame. A beat is consumed only on a cycle where `s_tvalid_i` and `s_tready_o` are both high.
- R2: When no frame is open and `s_tvalid_i` is high, the next output slot is a start word: logical byte 0 = 0x5C and byte 1 = 0xFB, both flagged as control. `s_tready_o` stays low during that cycle.
- R3: An accepted beat that is not the last appears in the next slot. Its bytes keep their order (`s_tdata_i[7:0]` is logical byte 0) and all control flags are 0.
- R4: While a frame is open, a cycle with `s_tvalid_i` low produces an idle slot. Every byte is 0xBC with its control flag set, and the frame stays open.
- R5: After the slot that carries an accepted last beat, the next slot is an end word: logical byte 0 = 0x5C and byte 1 = 0xFE, both control. `s_tready_o` is low during that slot, so a beat already waiting for the next frame is not consumed.
- R6: On a last beat, `s_tkeep_i` is a mask whose ones are contiguous from bit 0, and its population count c gives the number of valid bytes. Logical bytes below c carry data. Bytes at c and above carry pad 0x9C with the control flag set.
- R7: A last beat with `s_tkeep_i` all zero still forms a complete frame, and its slot is entirely pad symbols.
- R8: On a beat that is not the last, `s_tkeep_i` has no effect, and every byte is sent as data.
- R9: Logical byte k goes to lane k mod LANES, at in-lane position k div LANES. Lane l, position j sits at output byte l*2+j. In delimiter words, logical bytes from 2 upward are idle.
- R10: An active-low asynchronous reset immediately sets the output to idle symbols and `s_tready_o` low, and it drops any frame in progress.
- R11: With no frame open and `s_tvalid_i` low, every output slot is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_tdata_i | input | LANES*16 | Stream data, byte 0 in the low bits |
| s_tvalid_i | input | 1 | Stream beat valid |
| s_tready_o | output | 1 | Beat accepted when high together with valid |
| s_tlast_i | input | 1 | Marks the final beat of a frame |
| s_tkeep_i | input | LANES*2 | Valid-byte mask for the final beat |
| lane_data_o | output | LANES*16 | Lane bytes, lane l at bits [l*16 +: 16] |
| lane_ctrl_o | output | LANES*2 | Control flag per output byte |

## Verification
The assertions assume that the upstream holds `s_tvalid_i` and its beat steady until the beat is consumed. They also assume that `s_tkeep_i` on a last beat is a contiguous mask starting at bit 0. The stimulus drives inputs only on falling edges and keeps every beat, including one that waits behind an end word, stable until a ready cycle takes it. Last-beat masks used in the stimulus are 0, 1, 3 and 7.

// File: rtl/tx_frame_pkg.sv
package tx_frame_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_EOF  = 2'd2
  } frm_state_e;
endpackage

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
  import tx_frame_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       last_i,
  output logic       ready_o,
  output frm_state_e state_o
);
  frm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (valid_i) state_d = ST_DATA;
      ST_DATA: if (valid_i && last_i) state_d = ST_EOF;
      ST_EOF:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ready_o = (state_q == ST_DATA);
  assign state_o = state_q;

  AST_NO_READY_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && last_i) |=> !ready_o); // R5
  AST_OPEN_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && state_q == ST_IDLE && valid_i) |=> ready_o); // R1
endmodule

// File: rtl/tx_slot_builder.sv
module tx_slot_builder
  import tx_frame_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 2,
  parameter logic [7:0]  SYM_IDLE   = 8'hBC,
  parameter logic [7:0]  SYM_SOF0   = 8'h5C,
  parameter logic [7:0]  SYM_SOF1   = 8'hFB,
  parameter logic [7:0]  SYM_EOF0   = 8'h5C,
  parameter logic [7:0]  SYM_EOF1   = 8'hFE,
  parameter logic [7:0]  SYM_PAD    = 8'h9C,
  localparam int unsigned DW    = WORD_BYTES * 8,
  localparam int unsigned CNT_W = $clog2(WORD_BYTES + 1)
) (
  input  frm_state_e            state_i,
  input  logic                  valid_i,
  input  logic                  last_i,
  input  logic [WORD_BYTES-1:0] keep_i,
  input  logic [DW-1:0]         data_i,
  output logic [DW-1:0]         slot_data_o,
  output logic [WORD_BYTES-1:0] slot_ctrl_o
);
  logic [CNT_W-1:0]      keep_cnt;
  logic [WORD_BYTES-1:0] is_data;
  logic [DW-1:0]         body_data;

  assign keep_cnt = CNT_W'($countones(keep_i));

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
    // non-last beats ignore keep
    assign is_data[b] = !last_i || (CNT_W'(b) < keep_cnt);
    assign body_data[b*8 +: 8] = is_data[b] ? data_i[b*8 +: 8] : SYM_PAD;
  end

  always_comb begin
    slot_data_o = {WORD_BYTES{SYM_IDLE}};
    slot_ctrl_o = '1;
    unique case (state_i)
      ST_IDLE: if (valid_i) begin
        slot_data_o[7:0]  = SYM_SOF0;
        slot_data_o[15:8] = SYM_SOF1;
      end
      ST_DATA: if (valid_i) begin
        slot_data_o = body_data;
        slot_ctrl_o = ~is_data;
      end
      ST_EOF: begin
        slot_data_o[7:0]  = SYM_EOF0;
        slot_data_o[15:8] = SYM_EOF1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tx_lane_stripe.sv
module tx_lane_stripe #(
  parameter int unsigned LANES      = 1,
  parameter int unsigned LANE_BYTES = 2,
  localparam int unsigned WB = LANES * LANE_BYTES
) (
  input  logic [WB*8-1:0] slot_data_i,
  input  logic [WB-1:0]   slot_ctrl_i,
  output logic [WB*8-1:0] lane_data_o,
  output logic [WB-1:0]   lane_ctrl_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar j = 0; j < LANE_BYTES; j++) begin : g_pos
      // logical byte j*LANES+l -> lane l, position j
      assign lane_data_o[(l*LANE_BYTES+j)*8 +: 8] = slot_data_i[(j*LANES+l)*8 +: 8];
      assign lane_ctrl_o[l*LANE_BYTES+j]          = slot_ctrl_i[j*LANES+l];
    end
  end
endmodule

// File: rtl/tx_frame_encap.sv
module tx_frame_encap
  import tx_frame_pkg::*;
#(
  parameter int unsigned LANES      = 1,
  parameter int unsigned LANE_BYTES = 2,
  parameter logic [7:0]  SYM_IDLE   = 8'hBC,
  parameter logic [7:0]  SYM_SOF0   = 8'h5C,
  parameter logic [7:0]  SYM_SOF1   = 8'hFB,
  parameter logic [7:0]  SYM_EOF0   = 8'h5C,
  parameter logic [7:0]  SYM_EOF1   = 8'hFE,
  parameter logic [7:0]  SYM_PAD    = 8'h9C,
  localparam int unsigned WB = LANES * LANE_BYTES,
  localparam int unsigned DW = WB * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] s_tdata_i,
  input  logic          s_tvalid_i,
  output logic          s_tready_o,
  input  logic          s_tlast_i,
  input  logic [WB-1:0] s_tkeep_i,
  output logic [DW-1:0] lane_data_o,
  output logic [WB-1:0] lane_ctrl_o
);
  frm_state_e    state_w;
  logic [DW-1:0] slot_data_d, slot_q;
  logic [WB-1:0] slot_ctrl_d, ctrl_q;

  tx_frame_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s_tvalid_i),
    .last_i  (s_tlast_i),
    .ready_o (s_tready_o),
    .state_o (state_w)
  );

  tx_slot_builder #(
    .WORD_BYTES (WB),
    .SYM_IDLE   (SYM_IDLE),
    .SYM_SOF0   (SYM_SOF0),
    .SYM_SOF1   (SYM_SOF1),
    .SYM_EOF0   (SYM_EOF0),
    .SYM_EOF1   (SYM_EOF1),
    .SYM_PAD    (SYM_PAD)
  ) u_build (
    .state_i     (state_w),
    .valid_i     (s_tvalid_i),
    .last_i      (s_tlast_i),
    .keep_i      (s_tkeep_i),
    .data_i      (s_tdata_i),
    .slot_data_o (slot_data_d),
    .slot_ctrl_o (slot_ctrl_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= {WB{SYM_IDLE}};
      ctrl_q <= '1;
    end else begin
      slot_q <= slot_data_d;
      ctrl_q <= slot_ctrl_d;
    end
  end

  tx_lane_stripe #(
    .LANES      (LANES),
    .LANE_BYTES (LANE_BYTES)
  ) u_stripe (
    .slot_data_i (slot_q),
    .slot_ctrl_i (ctrl_q),
    .lane_data_o (lane_data_o),
    .lane_ctrl_o (lane_ctrl_o)
  );

  AST_SOF_LEADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == ST_IDLE && s_tvalid_i) |=>
      (slot_q[7:0] == SYM_SOF0 && slot_q[15:8] == SYM_SOF1 && ctrl_q[1:0] == 2'b11)); // R2
  AST_DATA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_tvalid_i && s_tready_o && !s_tlast_i) |=>
      (slot_q == $past(s_tdata_i) && ctrl_q == '0)); // R3
  AST_STALL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == ST_DATA && !s_tvalid_i) |=>
      (slot_q == {WB{SYM_IDLE}} && ctrl_q == '1)); // R4
  AST_EOF_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_tvalid_i && s_tready_o && s_tlast_i) |=> ##1
      (slot_q[7:0] == SYM_EOF0 && slot_q[15:8] == SYM_EOF1 && ctrl_q[1:0] == 2'b11)); // R5
endmodule

// File: tb/tx_frame_encap_test.sv
`timescale 1ns/1ps
module tx_frame_encap_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] tdata = '0;
  logic        tvalid = 1'b0, tlast = 1'b0;
  logic [1:0]  tkeep = '0;
  logic        tready;
  logic [15:0] ldata;
  logic [1:0]  lctrl;

  logic [31:0] w_data = '0;
  logic        w_valid = 1'b0, w_last = 1'b0;
  logic [3:0]  w_keep = '0;
  logic        w_ready;
  logic [31:0] w_ldata;
  logic [3:0]  w_lctrl;

  int  n_cmp = 0, n_mis = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  tx_frame_encap uut (
    .clk_i(clk), .rst_ni(rst_ni), .s_tdata_i(tdata), .s_tvalid_i(tvalid),
    .s_tready_o(tready), .s_tlast_i(tlast), .s_tkeep_i(tkeep),
    .lane_data_o(ldata), .lane_ctrl_o(lctrl));

  tx_frame_encap #(.LANES(2)) uut_w (
    .clk_i(clk), .rst_ni(rst_ni), .s_tdata_i(w_data), .s_tvalid_i(w_valid),
    .s_tready_o(w_ready), .s_tlast_i(w_last), .s_tkeep_i(w_keep),
    .lane_data_o(w_ldata), .lane_ctrl_o(w_lctrl));

  // {valid, last, keep, data, exp_ready, exp_out_data, exp_out_ctrl}
  localparam int NV = 18;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0,1'b0,2'b00,16'h0000,1'b0,16'hBCBC,2'b11},
    {1'b1,1'b0,2'b00,16'h1122,1'b0,16'hFB5C,2'b11},
    {1'b1,1'b0,2'b00,16'h1122,1'b1,16'h1122,2'b00},
    {1'b0,1'b0,2'b00,16'h0000,1'b1,16'hBCBC,2'b11},
    {1'b1,1'b1,2'b11,16'h3344,1'b1,16'h3344,2'b00},
    {1'b0,1'b0,2'b00,16'h0000,1'b0,16'hFE5C,2'b11},
    {1'b1,1'b1,2'b01,16'h5566,1'b0,16'hFB5C,2'b11},
    {1'b1,1'b1,2'b01,16'h5566,1'b1,16'h9C66,2'b10},
    {1'b1,1'b1,2'b00,16'h7788,1'b0,16'hFE5C,2'b11},
    {1'b1,1'b1,2'b00,16'h7788,1'b0,16'hFB5C,2'b11},
    {1'b1,1'b1,2'b00,16'h7788,1'b1,16'h9C9C,2'b11},
    {1'b0,1'b0,2'b00,16'h0000,1'b0,16'hFE5C,2'b11},
    {1'b0,1'b0,2'b00,16'h0000,1'b0,16'hBCBC,2'b11},
    {1'b1,1'b0,2'b00,16'hAABB,1'b0,16'hFB5C,2'b11},
    {1'b1,1'b0,2'b00,16'hAABB,1'b1,16'hAABB,2'b00},
    {1'b1,1'b1,2'b11,16'hCCDD,1'b1,16'hCCDD,2'b00},
    {1'b0,1'b0,2'b00,16'h0000,1'b0,16'hFE5C,2'b11},
    {1'b0,1'b0,2'b00,16'h0000,1'b0,16'hBCBC,2'b11}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 12, 17:    return "R11";
      1, 6, 9, 13:  return "R2";
      2:            return "R3";
      3:            return "R4";
      4, 7, 15:     return "R6";
      5, 8, 11, 16: return "R5";
      10:           return "R7";
      14:           return "R8";
      default:      return "R3";
    endcase
  endfunction

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_mis++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {18'd0, lctrl, ldata}, {18'd0, 2'b11, 16'hBCBC});
    chk("R10", {35'd0, tready}, 36'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) chk(tag_of(i-1), {18'd0, lctrl, ldata}, {18'd0, VEC[i-1][1:0], VEC[i-1][17:2]});
      chk("R1", {35'd0, tready}, {35'd0, VEC[i][18]});
      {tvalid, tlast, tkeep, tdata} = VEC[i][38:19];
    end
    @(negedge clk);
    chk(tag_of(NV-1), {18'd0, lctrl, ldata}, {18'd0, VEC[NV-1][1:0], VEC[NV-1][17:2]});

    // R10: reset mid-frame drops partial frame
    tvalid = 1'b1; tlast = 1'b0; tkeep = 2'b00; tdata = 16'h1234;
    @(negedge clk);
    chk("R1", {35'd0, tready}, 36'd1);
    rst_ni = 1'b0;
    #1;
    chk("R10", {18'd0, lctrl, ldata}, {18'd0, 2'b11, 16'hBCBC});
    chk("R10", {35'd0, tready}, 36'd0);
    tvalid = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10", {18'd0, lctrl, ldata}, {18'd0, 2'b11, 16'hBCBC});
    tvalid = 1'b1; tlast = 1'b1; tkeep = 2'b11; tdata = 16'h5678;
    @(negedge clk);
    chk("R10", {18'd0, lctrl, ldata}, {18'd0, 2'b11, 16'hFB5C});
    @(negedge clk);
    chk("R10", {18'd0, lctrl, ldata}, {18'd0, 2'b00, 16'h5678});
    tvalid = 1'b0;
    @(negedge clk);
    chk("R5", {18'd0, lctrl, ldata}, {18'd0, 2'b11, 16'hFE5C});

    // R9: two-lane striping
    w_valid = 1'b1; w_last = 1'b1; w_keep = 4'b0111; w_data = 32'h44332211;
    @(negedge clk);
    chk("R9", {w_lctrl, w_ldata}, {4'b1111, 32'hBCFBBC5C});
    chk("R1", {35'd0, w_ready}, 36'd1);
    @(negedge clk);
    chk("R9", {w_lctrl, w_ldata}, {4'b1000, 32'h9C223311});
    w_valid = 1'b0;
    @(negedge clk);
    chk("R9", {w_lctrl, w_ldata}, {4'b1111, 32'hBCFEBC5C});
    chk("R5", {35'd0, w_ready}, 36'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule